// File: doc/BRIEF.md
# Almost-Flag Offset Register Programmer

This block holds the four threshold offsets used by the almost-empty and almost-full flags of a two-FIFO buffer. FIFO1 owns an almost-empty offset (`ae1_ofs`) and an almost-full offset (`af1_ofs`). FIFO2 owns `ae2_ofs` and `af2_ofs`. Every register is cleared while its FIFO's master reset is held low. The offsets are then set in one of two ways. A preset is picked by the code on the three flag-select lines when a reset is released. Otherwise the offsets are captured from the first four data writes after both resets are released together.

In the capture method, two layouts of the write data are supported. In the plain layout, the offset is the low bits of the word. In the parity layout, data bit 8 carries parity and is skipped. The captured writes never reach the memory write port. Once the offsets are in place, `ofs_done` goes high and data writes pass through to the memory port unchanged.

The controller is a state machine with seven states. `ST_HOLD` covers reset and waiting for the release. `ST_LD_Y1`, `ST_LD_X1`, `ST_LD_Y2` and `ST_LD_X2` capture one offset each. `ST_READY` is normal operation. `ST_SERIAL` is the bit-serial code, which this block parks without loading anything.

Its transitions are:
- Any reset low goes to `ST_HOLD`.
- `ST_HOLD` goes to `ST_LD_Y1` when both resets rise together with a parallel code.
- `ST_HOLD` goes to `ST_SERIAL` when a release sees the serial code.
- `ST_HOLD` goes to `ST_READY` when both FIFOs hold presets.
- Each `ST_LD_*` state moves to the next one on a write: Y1, then X1, then Y2, then X2.
- `ST_LD_X2` moves to `ST_READY` on a write.

Top module: `ofs_prog`

## Requirements
- R1: While `mrst1_n` is low, `ae1_ofs` and `af1_ofs` read 0 from the next clock. While `mrst2_n` is low, `ae2_ofs` and `af2_ofs` read 0 from the next clock. While either reset is low, `ofs_done` and `mem_wr_en` are 0.
- R2: On the first clock with `mrst1_n` high after it was low, a preset code on `fsel` ({FS2,FS1,FS0}) loads both FIFO1 offsets from the next cycle. The codes are 3'b111→64, 3'b110→16, 3'b101→8, 3'b011→256 and 3'b001→1024.
- R3: The FIFO2 offsets take a preset from the `fsel` code seen at the release of `mrst2_n`, using the same codes. This is independent of the FIFO1 preset.
- R4: `ofs_done` goes high one cycle after the clock at which both FIFOs have taken a preset and both resets are high.
- R5: If both resets are released at the same clock with code 3'b100 or 3'b000, the next four writes load the offsets in the order `af1_ofs`, `ae1_ofs`, `af2_ofs`, `ae2_ofs`. `mem_wr_en` stays 0 during these writes.
- R6: With code 3'b100, a captured offset is `wr_data[10:0]`, with bit 10 as the MSB.
- R7: With code 3'b000, a captured offset is {`wr_data[11:9]`, `wr_data[7:0]`}. Bit 8 and bits above 11 have no effect.
- R8: `ofs_done` is high from the cycle after the fourth capture write. From then on, a write drives `mem_wr_en` high in the same cycle with `mem_wr_data` equal to `wr_data`, and the offsets do not change.
- R9: Code 3'b010 seen at a release leaves all offsets at 0 and `ofs_done` low, and blocks memory writes.
- R10: A parallel code at a release that is not shared by both resets starts no capture. The offsets stay 0, `ofs_done` stays low and writes are blocked.
- R11: A cycle with `wr_en` low during capture loads nothing and does not advance the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst1_n | input | 1 | FIFO1 master reset, active low, sampled on clk |
| mrst2_n | input | 1 | FIFO2 master reset, active low, sampled on clk |
| fsel | input | 3 | Flag-select code {FS2,FS1,FS0} |
| wr_en | input | 1 | Data write strobe |
| wr_data | input | 36 | Data write word |
| mem_wr_en | output | 1 | Write strobe forwarded to memory |
| mem_wr_data | output | 36 | Write word forwarded to memory |
| ofs_done | output | 1 | Offsets are established |
| ae1_ofs | output | 11 | FIFO1 almost-empty offset |
| af1_ofs | output | 11 | FIFO1 almost-full offset |
| ae2_ofs | output | 11 | FIFO2 almost-empty offset |
| af2_ofs | output | 11 | FIFO2 almost-full offset |

## Verification
A wrong state in the capture sequence shows up at the ports one cycle after the write that should have closed it. The offset that was due appears in the wrong output, or `ofs_done` rises one write early or one write late. A controller that takes the wrong decision at a release shows up one cycle after the release edge. The symptom is a preset that is missing or wrong, or `ofs_done` staying low. A write leaking to memory shows up in the same cycle as a high `mem_wr_en` while `ofs_done` is still low. The bench therefore checks offsets and `ofs_done` one cycle after every release and capture write, and checks `mem_wr_en` within each write cycle.

// File: rtl/ofs_prog_pkg.sv
package ofs_prog_pkg;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_LD_Y1,
        ST_LD_X1,
        ST_LD_Y2,
        ST_LD_X2,
        ST_READY,
        ST_SERIAL
    } ofs_state_e;

    // Flag-select codes, {FS2,FS1,FS0}
    localparam logic [2:0] CODE_P64    = 3'b111;
    localparam logic [2:0] CODE_P16    = 3'b110;
    localparam logic [2:0] CODE_P8     = 3'b101;
    localparam logic [2:0] CODE_P256   = 3'b011;
    localparam logic [2:0] CODE_P1024  = 3'b001;
    localparam logic [2:0] CODE_SERIAL = 3'b010;
    localparam logic [2:0] CODE_PAR    = 3'b100;
    localparam logic [2:0] CODE_PAR_IP = 3'b000;

    // Load strobe slots, in capture order
    localparam int SLOT_Y1 = 0;
    localparam int SLOT_X1 = 1;
    localparam int SLOT_Y2 = 2;
    localparam int SLOT_X2 = 3;
    localparam int N_SLOTS = 4;

    // Data bit that carries parity in the interspersed layout
    localparam int PAR_BIT = 8;

endpackage

// File: rtl/ofs_rel_det.sv
module ofs_rel_det (
    input  logic clk,
    input  logic rst_n,
    output logic rel
);
    logic rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst_n;
    end

    assign rel = rst_n & ~rst_q;
endmodule

// File: rtl/ofs_code_dec.sv
module ofs_code_dec
    import ofs_prog_pkg::*;
#(
    parameter int OFS_W = 11
) (
    input  logic [2:0]       code,
    output logic             is_preset,
    output logic             is_par,
    output logic             is_ip,
    output logic             is_serial,
    output logic [OFS_W-1:0] preset_val
);
    always_comb begin
        is_preset  = 1'b0;
        is_par     = 1'b0;
        is_ip      = 1'b0;
        is_serial  = 1'b0;
        preset_val = '0;
        unique case (code)
            CODE_P64: begin
                is_preset  = 1'b1;
                preset_val = OFS_W'(64);
            end
            CODE_P16: begin
                is_preset  = 1'b1;
                preset_val = OFS_W'(16);
            end
            CODE_P8: begin
                is_preset  = 1'b1;
                preset_val = OFS_W'(8);
            end
            CODE_P256: begin
                is_preset  = 1'b1;
                preset_val = OFS_W'(256);
            end
            CODE_P1024: begin
                is_preset  = 1'b1;
                preset_val = OFS_W'(1024);
            end
            CODE_SERIAL: begin
                is_serial = 1'b1;
            end
            CODE_PAR: begin
                is_par = 1'b1;
            end
            CODE_PAR_IP: begin
                is_par = 1'b1;
                is_ip  = 1'b1;
            end
            default: begin
                is_preset = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/ofs_field_ext.sv
module ofs_field_ext
    import ofs_prog_pkg::*;
#(
    parameter int OFS_W = 11
) (
    input  logic [OFS_W:0]   data,
    input  logic             ip_mode,
    output logic [OFS_W-1:0] field
);
    localparam int HI_W = OFS_W - PAR_BIT;

    logic [OFS_W-1:0] plain_f;
    logic [OFS_W-1:0] ip_f;

    generate
        if (HI_W > 0) begin : g_ip_split
            assign ip_f = {data[OFS_W:PAR_BIT+1], data[PAR_BIT-1:0]};
        end else begin : g_ip_low
            assign ip_f = data[OFS_W-1:0];
        end
    endgenerate

    assign plain_f = data[OFS_W-1:0];
    assign field   = ip_mode ? ip_f : plain_f;
endmodule

// File: rtl/ofs_load_fsm.sv
module ofs_load_fsm
    import ofs_prog_pkg::*;
(
    input  logic               clk,
    input  logic               rst1_n,
    input  logic               rst2_n,
    input  logic               rel1,
    input  logic               rel2,
    input  logic               code_preset,
    input  logic               code_par,
    input  logic               code_ip,
    input  logic               code_serial,
    input  logic               wr_en,
    output logic [N_SLOTS-1:0] ld_stb,
    output logic               ip_mode,
    output logic               done,
    output logic               pass
);
    ofs_state_e state_q, state_d;
    logic cfg1_q, cfg1_d;
    logic cfg2_q, cfg2_d;
    logic ip_q, ip_d;

    // Next-state process
    always_comb begin
        cfg1_d  = !rst1_n ? 1'b0 : (rel1 ? code_preset : cfg1_q);
        cfg2_d  = !rst2_n ? 1'b0 : (rel2 ? code_preset : cfg2_q);
        ip_d    = ip_q;
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: begin
                if (rst1_n && rst2_n) begin
                    if (rel1 && rel2 && code_par) begin
                        state_d = ST_LD_Y1;
                        ip_d    = code_ip;
                    end else if ((rel1 || rel2) && code_serial) begin
                        state_d = ST_SERIAL;
                    end else if (cfg1_d && cfg2_d) begin
                        state_d = ST_READY;
                    end
                end
            end
            ST_LD_Y1:  if (wr_en) state_d = ST_LD_X1;
            ST_LD_X1:  if (wr_en) state_d = ST_LD_Y2;
            ST_LD_Y2:  if (wr_en) state_d = ST_LD_X2;
            ST_LD_X2:  if (wr_en) state_d = ST_READY;
            ST_READY:  state_d = ST_READY;
            ST_SERIAL: state_d = ST_SERIAL;
            default:   state_d = ST_HOLD;
        endcase
        if (!rst1_n || !rst2_n) begin
            state_d = ST_HOLD;
        end
    end

    // State register process
    always_ff @(posedge clk) begin
        state_q <= state_d;
        cfg1_q  <= cfg1_d;
        cfg2_q  <= cfg2_d;
        ip_q    <= ip_d;
    end

    // Output process
    always_comb begin
        ld_stb = '0;
        done   = 1'b0;
        pass   = 1'b0;
        unique case (state_q)
            ST_LD_Y1: ld_stb[SLOT_Y1] = wr_en;
            ST_LD_X1: ld_stb[SLOT_X1] = wr_en;
            ST_LD_Y2: ld_stb[SLOT_Y2] = wr_en;
            ST_LD_X2: ld_stb[SLOT_X2] = wr_en;
            ST_READY: begin
                done = 1'b1;
                pass = wr_en;
            end
            ST_HOLD, ST_SERIAL: begin
                done = 1'b0;
            end
            default: begin
                done = 1'b0;
            end
        endcase
    end

    assign ip_mode = ip_q;
endmodule

// File: rtl/ofs_regs.sv
module ofs_regs
    import ofs_prog_pkg::*;
#(
    parameter int OFS_W = 11
) (
    input  logic               clk,
    input  logic               rst1_n,
    input  logic               rst2_n,
    input  logic               pre1,
    input  logic               pre2,
    input  logic [OFS_W-1:0]   preset_val,
    input  logic [N_SLOTS-1:0] ld_stb,
    input  logic [OFS_W-1:0]   field,
    output logic [OFS_W-1:0]   ae1,
    output logic [OFS_W-1:0]   af1,
    output logic [OFS_W-1:0]   ae2,
    output logic [OFS_W-1:0]   af2
);
    always_ff @(posedge clk) begin
        if (!rst1_n) begin
            ae1 <= '0;
            af1 <= '0;
        end else if (pre1) begin
            ae1 <= preset_val;
            af1 <= preset_val;
        end else begin
            if (ld_stb[SLOT_Y1]) af1 <= field;
            if (ld_stb[SLOT_X1]) ae1 <= field;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst2_n) begin
            ae2 <= '0;
            af2 <= '0;
        end else if (pre2) begin
            ae2 <= preset_val;
            af2 <= preset_val;
        end else begin
            if (ld_stb[SLOT_Y2]) af2 <= field;
            if (ld_stb[SLOT_X2]) ae2 <= field;
        end
    end
endmodule

// File: rtl/ofs_prog.sv
module ofs_prog
    import ofs_prog_pkg::*;
#(
    parameter int DEPTH  = 2048,
    parameter int DATA_W = 36,
    localparam int OFS_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              mrst1_n,
    input  logic              mrst2_n,
    input  logic [2:0]        fsel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              mem_wr_en,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic              ofs_done,
    output logic [OFS_W-1:0]  ae1_ofs,
    output logic [OFS_W-1:0]  af1_ofs,
    output logic [OFS_W-1:0]  ae2_ofs,
    output logic [OFS_W-1:0]  af2_ofs
);
    logic [1:0]         rst_n_v;
    logic [1:0]         rel_v;
    logic               c_preset, c_par, c_ip, c_serial;
    logic [OFS_W-1:0]   preset_val;
    logic [OFS_W-1:0]   field;
    logic [N_SLOTS-1:0] ld_stb;
    logic               ip_mode;
    logic               pass;

    assign rst_n_v = {mrst2_n, mrst1_n};

    generate
        for (genvar g = 0; g < 2; g++) begin : g_rel
            ofs_rel_det u_rel (
                .clk  (clk),
                .rst_n(rst_n_v[g]),
                .rel  (rel_v[g])
            );
        end
    endgenerate

    ofs_code_dec #(.OFS_W(OFS_W)) u_dec (
        .code      (fsel),
        .is_preset (c_preset),
        .is_par    (c_par),
        .is_ip     (c_ip),
        .is_serial (c_serial),
        .preset_val(preset_val)
    );

    ofs_field_ext #(.OFS_W(OFS_W)) u_ext (
        .data   (wr_data[OFS_W:0]),
        .ip_mode(ip_mode),
        .field  (field)
    );

    ofs_load_fsm u_fsm (
        .clk        (clk),
        .rst1_n     (mrst1_n),
        .rst2_n     (mrst2_n),
        .rel1       (rel_v[0]),
        .rel2       (rel_v[1]),
        .code_preset(c_preset),
        .code_par   (c_par),
        .code_ip    (c_ip),
        .code_serial(c_serial),
        .wr_en      (wr_en),
        .ld_stb     (ld_stb),
        .ip_mode    (ip_mode),
        .done       (ofs_done),
        .pass       (pass)
    );

    ofs_regs #(.OFS_W(OFS_W)) u_regs (
        .clk       (clk),
        .rst1_n    (mrst1_n),
        .rst2_n    (mrst2_n),
        .pre1      (rel_v[0] & c_preset),
        .pre2      (rel_v[1] & c_preset),
        .preset_val(preset_val),
        .ld_stb    (ld_stb),
        .field     (field),
        .ae1       (ae1_ofs),
        .af1       (af1_ofs),
        .ae2       (ae2_ofs),
        .af2       (af2_ofs)
    );

    assign mem_wr_en   = pass;
    assign mem_wr_data = wr_data;
endmodule

// File: rtl/ofs_prog_chk.sv
module ofs_prog_chk #(
    parameter int OFS_W = 11
) (
    input logic             clk,
    input logic             mrst1_n,
    input logic             mrst2_n,
    input logic [2:0]       fsel,
    input logic             wr_en,
    input logic             mem_wr_en,
    input logic             ofs_done,
    input logic [3:0]       ld_stb,
    input logic [OFS_W-1:0] ae1_ofs,
    input logic [OFS_W-1:0] af1_ofs,
    input logic [OFS_W-1:0] ae2_ofs,
    input logic [OFS_W-1:0] af2_ofs
);
    assert_rst1_clear_R1: assert property (@(posedge clk)
        !mrst1_n |=> (ae1_ofs == '0 && af1_ofs == '0 && !ofs_done));

    assert_rst2_clear_R1: assert property (@(posedge clk)
        !mrst2_n |=> (ae2_ofs == '0 && af2_ofs == '0 && !ofs_done));

    assert_preset64_R2: assert property (@(posedge clk) disable iff (!mrst1_n)
        ($rose(mrst1_n) && fsel == 3'b111) |=>
            (ae1_ofs == OFS_W'(64) && af1_ofs == OFS_W'(64)));

    assert_preset1024_R3: assert property (@(posedge clk) disable iff (!mrst2_n)
        ($rose(mrst2_n) && fsel == 3'b001) |=>
            (ae2_ofs == OFS_W'(1024) && af2_ofs == OFS_W'(1024)));

    assert_no_mem_before_done_R5: assert property (@(posedge clk)
        disable iff (!mrst1_n || !mrst2_n)
        mem_wr_en |-> ofs_done);

    assert_one_slot_R5: assert property (@(posedge clk)
        disable iff (!mrst1_n || !mrst2_n)
        $onehot0(ld_stb));

    assert_pass_R8: assert property (@(posedge clk)
        disable iff (!mrst1_n || !mrst2_n)
        (ofs_done && wr_en) |-> mem_wr_en);

    assert_stable_R8: assert property (@(posedge clk)
        disable iff (!mrst1_n || !mrst2_n)
        ofs_done |=> ($stable(ae1_ofs) && $stable(af1_ofs) &&
                      $stable(ae2_ofs) && $stable(af2_ofs)));
endmodule

bind ofs_prog ofs_prog_chk #(.OFS_W(OFS_W)) chk_i (
    .clk      (clk),
    .mrst1_n  (mrst1_n),
    .mrst2_n  (mrst2_n),
    .fsel     (fsel),
    .wr_en    (wr_en),
    .mem_wr_en(mem_wr_en),
    .ofs_done (ofs_done),
    .ld_stb   (ld_stb),
    .ae1_ofs  (ae1_ofs),
    .af1_ofs  (af1_ofs),
    .ae2_ofs  (ae2_ofs),
    .af2_ofs  (af2_ofs)
);

// File: tb/ofs_prog_tb.sv
module ofs_prog_tb_top;
    localparam int DEPTH  = 2048;
    localparam int DATA_W = 36;
    localparam int OFS_W  = $clog2(DEPTH);
    localparam int NV     = 5;

    // Preset table: FIFO1 code, FIFO2 code, expected FIFO1, expected FIFO2
    localparam logic [2:0] V_C1 [NV] = '{3'b111, 3'b110, 3'b101, 3'b011, 3'b001};
    localparam logic [2:0] V_C2 [NV] = '{3'b001, 3'b011, 3'b111, 3'b101, 3'b110};
    localparam int         V_E1 [NV] = '{64, 16, 8, 256, 1024};
    localparam int         V_E2 [NV] = '{1024, 256, 64, 8, 16};

    logic              clk = 1'b0;
    logic              mrst1_n = 1'b0;
    logic              mrst2_n = 1'b0;
    logic [2:0]        fsel = 3'b111;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              mem_wr_en;
    logic [DATA_W-1:0] mem_wr_data;
    logic              ofs_done;
    logic [OFS_W-1:0]  ae1_ofs, af1_ofs, ae2_ofs, af2_ofs;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ofs_prog #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .mrst1_n(mrst1_n), .mrst2_n(mrst2_n), .fsel(fsel),
        .wr_en(wr_en), .wr_data(wr_data), .mem_wr_en(mem_wr_en),
        .mem_wr_data(mem_wr_data), .ofs_done(ofs_done),
        .ae1_ofs(ae1_ofs), .af1_ofs(af1_ofs), .ae2_ofs(ae2_ofs), .af2_ofs(af2_ofs)
    );

    task automatic check(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic hold_reset();
        wr_en   = 1'b0;
        mrst1_n = 1'b0;
        mrst2_n = 1'b0;
        repeat (2) step();
    endtask

    task automatic cap_write(input logic [DATA_W-1:0] d, input string req);
        wr_en   = 1'b1;
        wr_data = d;
        #1;
        check({req, " capture write blocked"}, mem_wr_en, 0);
        step();
        wr_en = 1'b0;
        #1;
    endtask

    function automatic longint ip_field(input logic [DATA_W-1:0] d);
        return longint'({d[11:9], d[7:0]});
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        hold_reset();
        // R1 reset state
        check("R1 ae1", ae1_ofs, 0);
        check("R1 af2", af2_ofs, 0);
        check("R1 done", ofs_done, 0);
        wr_en = 1'b1; #1;
        check("R1 mem_wr_en", mem_wr_en, 0);
        wr_en = 1'b0;

        // R2/R3/R4 preset table
        for (int i = 0; i < NV; i++) begin
            hold_reset();
            fsel = V_C1[i];
            mrst1_n = 1'b1;
            step();
            check("R2 ae1", ae1_ofs, V_E1[i]);
            check("R2 af1", af1_ofs, V_E1[i]);
            check("R4 done early", ofs_done, 0);
            fsel = V_C2[i];
            mrst2_n = 1'b1;
            step();
            check("R3 ae2", ae2_ofs, V_E2[i]);
            check("R3 af2", af2_ofs, V_E2[i]);
            check("R3 ae1 kept", ae1_ofs, V_E1[i]);
            check("R4 done", ofs_done, 1);
            wr_en = 1'b1; wr_data = 36'h5_A5A5_0F0F; #1;
            check("R8 preset pass en", mem_wr_en, 1);
            check("R8 preset pass data", mem_wr_data, 36'h5_A5A5_0F0F);
            step();
            wr_en = 1'b0;
        end

        // R1 reset clears FIFO1 only while FIFO2 keeps its preset
        mrst1_n = 1'b0;
        step();
        check("R1 ae1 clear", ae1_ofs, 0);
        check("R1 ae2 kept", ae2_ofs, 16);
        check("R1 done low", ofs_done, 0);

        // R5/R6/R8/R11 plain parallel capture
        hold_reset();
        fsel = 3'b100;
        mrst1_n = 1'b1; mrst2_n = 1'b1;
        step();
        check("R5 done during capture", ofs_done, 0);
        repeat (3) step();
        check("R11 idle no load", af1_ofs, 0);
        cap_write(36'hF_FFFF_F3FC, "R5");
        check("R6 af1", af1_ofs, 11'h3FC);
        check("R5 ae1 not yet", ae1_ofs, 0);
        cap_write(36'h8_0000_0001, "R5");
        check("R6 ae1", ae1_ofs, 1);
        step();
        check("R11 af2 idle", af2_ofs, 0);
        cap_write(36'h0_0000_07FC, "R5");
        check("R6 af2", af2_ofs, 2044);
        check("R8 done before 4th", ofs_done, 0);
        cap_write(36'h0_0000_0155, "R5");
        check("R6 ae2", ae2_ofs, 11'h155);
        check("R8 done", ofs_done, 1);
        wr_en = 1'b1; wr_data = 36'hC_3210_7654; #1;
        check("R8 pass en", mem_wr_en, 1);
        check("R8 pass data", mem_wr_data, 36'hC_3210_7654);
        step();
        wr_en = 1'b0;
        check("R8 af1 unchanged", af1_ofs, 11'h3FC);
        check("R8 ae2 unchanged", ae2_ofs, 11'h155);

        // R7 interspersed-parity capture, bit 8 set to show it is skipped
        hold_reset();
        fsel = 3'b000;
        mrst1_n = 1'b1; mrst2_n = 1'b1;
        step();
        cap_write(36'hF_0000_0D23, "R7");
        check("R7 af1", af1_ofs, ip_field(36'hF_0000_0D23));
        cap_write(36'h0_0000_0100, "R7");
        check("R7 ae1 bit8 only", ae1_ofs, 0);
        cap_write(36'h0_0000_0FFF, "R7");
        check("R7 af2", af2_ofs, ip_field(36'h0_0000_0FFF));
        cap_write(36'h0_0000_0A81, "R7");
        check("R7 ae2", ae2_ofs, ip_field(36'h0_0000_0A81));
        check("R7 done", ofs_done, 1);

        // R9 serial code
        hold_reset();
        fsel = 3'b010;
        mrst1_n = 1'b1; mrst2_n = 1'b1;
        step();
        wr_en = 1'b1; wr_data = 36'h0_0000_0123; #1;
        check("R9 mem blocked", mem_wr_en, 0);
        step();
        wr_en = 1'b0;
        check("R9 af1", af1_ofs, 0);
        check("R9 ae2", ae2_ofs, 0);
        check("R9 done", ofs_done, 0);

        // R10 parallel code with resets released apart
        hold_reset();
        fsel = 3'b100;
        mrst1_n = 1'b1;
        step();
        mrst2_n = 1'b1;
        step();
        wr_en = 1'b1; wr_data = 36'h0_0000_0077; #1;
        check("R10 mem blocked", mem_wr_en, 0);
        step();
        wr_en = 1'b0;
        check("R10 af1", af1_ofs, 0);
        check("R10 done", ofs_done, 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule